// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the programmed-I/O read and write strobes for one legacy parallel ATA channel that carries a master and a slave drive. A 16-bit timing control register holds an enable bit, a channel-position bit, one shared fast timing bank and a 3-bit control field for each drive. Each drive's field decides whether its cycles use the fast bank or the fixed compatible (PIO mode 0) timing. It also decides whether the drive's IORDY line may stretch a cycle and whether prefetch/posting is allowed. Only one fast bank exists, so only one drive can run tuned timing and the other stays at compatible speed.

The host asks for a cycle over a valid/ready request channel. The request carries direction, register address and write data. `req_ready` is high only while the function is enabled and no cycle is in flight. A request holds its fields stable while `req_valid` is high and not yet accepted. There is no back-pressure on read results: `rsp_valid` is a one-clock pulse that must be taken when it appears. The block watches host writes to the device/head register and uses the drive-select bit to choose which drive's field governs later cycles.

A cycle has three phases: address setup with chip-select low, an active strobe, and recovery with the strobe released. IORDY is sampled on the last clock of the active strobe. If IORDY is low there, the strobe is held until IORDY goes high or a timeout expires. A timeout sets a sticky error flag.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset the control register is zero, both strobes and chip-select are high (inactive), `busy`, `tmo_err`, `rsp_valid`, `post_en` and `chan_sec` are low, and `req_ready` is low.
- R2: While control bit 15 (enable) is clear, `req_ready` stays low and no strobe, chip-select or busy activity occurs, even with `req_valid` held high. With bit 15 set and no cycle in flight, `req_ready` is high.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the clock after acceptance until recovery ends, and `req_ready` is low for that whole time.
- R4: A drive whose field bit 0 is clear uses compatible timing. At the default 33 MHz clock parameter this is 3 setup clocks, 10 active-strobe clocks and 7 recovery clocks (70 ns, 290 ns and 600 ns cycle, each rounded up to whole clocks), whatever the fast-bank fields hold.
- R5: A drive whose field bit 0 is set uses the fast bank. It gets 1 setup clock and an active strobe of (bits 13:12 code + 2) clocks, so the IORDY sample point is 2 to 5. Recovery is (bits 9:8 code + 1) clocks, so 1 to 4.
- R6: Drive 0's field is bits 2:0 and drive 1's field is bits 6:4. Within a field, bit 0 selects the fast bank, bit 1 enables IORDY sampling and bit 2 enables prefetch/posting.
- R7: An accepted host write to address 6 (device/head) latches its data bit 4 as the drive select: 0 is drive 0, 1 is drive 1. The select governs cycles accepted after that write; the write itself uses the previous select. Reset selects drive 0.
- R8: With IORDY sampling enabled, IORDY low on the last active clock holds the strobe. The strobe is released after the first clock on which IORDY is seen high.
- R9: With IORDY sampling disabled, IORDY has no effect and the strobe length is exactly the programmed active time.
- R10: If IORDY stays low for 1024 wait clocks, the strobe is released and `tmo_err` is set. It stays set until reset.
- R11: During the active strobe, chip-select is low and `ata_da` carries the request address. A read strobes `ata_dior_n` only and captures `ata_dd_in` at its last strobe clock; `rsp_valid` pulses with that data in the first recovery clock. A write strobes `ata_diow_n` only, with `ata_dd_oe` high and `ata_dd_out` equal to the write data.
- R12: A control register write during a cycle does not change that cycle's timing. It takes effect from the next accepted cycle.
- R13: `chan_sec` follows control bit 14. `post_en` is high while busy on a cycle whose drive field has bit 2 set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| req_valid | input | 1 | Host cycle request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 3 | Task-file register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock read data pulse |
| rsp_rdata | output | 16 | Read data |
| busy | output | 1 | Cycle in flight |
| tmo_err | output | 1 | Sticky IORDY timeout flag |
| chan_sec | output | 1 | Channel is the secondary legacy channel |
| post_en | output | 1 | Prefetch/posting allowed for the current cycle |
| ata_cs_n | output | 1 | Command-block chip-select, active low |
| ata_da | output | 3 | Device address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus input value |
| ata_iordy | input | 1 | Drive ready, low stretches the strobe |

## Verification
The hardest state to reach is the IORDY timeout. To get there, the drive with sampling enabled has to meet a low IORDY at the exact sample clock, and the line has to stay low for a further 1024 clocks. The bench holds IORDY low from before the request until the cycle ends, so that path is taken. It runs this case last, because the error flag cannot be cleared except by reset. Drive-select switching is also reached only indirectly: the bench issues host writes to the device/head register and then checks the timing of the cycles that follow.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int CTRL_W  = 16;
  localparam int EN_BIT  = 15;
  localparam int SEC_BIT = 14;
  localparam int ISP_LSB = 12;
  localparam int RTC_LSB = 8;
  localparam int FLD_W   = 3;
  localparam int FLD_STRIDE = 4;
  localparam int NUM_DRV = 2;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ACT   = 3'd2,
    PH_WAIT  = 3'd3,
    PH_RECOV = 3'd4
  } phase_t;

  function automatic int ns2clk(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int DEVHEAD_ADDR = 6,
  parameter int DRV_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              acc,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              dev_sel
);

  logic hit_devhead;
  assign hit_devhead = acc && acc_write && (acc_addr == AW'(DEVHEAD_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (cfg_we) begin
      ctrl <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sel <= 1'b0;
    end else if (hit_devhead) begin
      dev_sel <= acc_wdata[DRV_BIT];
    end
  end

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_devhead |=> $stable(dev_sel));

endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_pkg::*;
#(
  parameter int CW = 5,
  parameter int FAST_SETUP = 1,
  parameter int SLOW_SETUP = 3,
  parameter int SLOW_ACT = 10,
  parameter int SLOW_REC = 7
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              dev_sel,
  output logic [CW-1:0]     s_len,
  output logic [CW-1:0]     a_len,
  output logic [CW-1:0]     r_len,
  output logic              iordy_en,
  output logic              post_sel
);

  logic [CW-1:0] fast_a, fast_r;
  logic [CW-1:0] d_s [NUM_DRV];
  logic [CW-1:0] d_a [NUM_DRV];
  logic [CW-1:0] d_r [NUM_DRV];
  logic          d_ien  [NUM_DRV];
  logic          d_post [NUM_DRV];

  assign fast_a = CW'(ctrl[ISP_LSB +: 2]) + CW'(2);
  assign fast_r = CW'(ctrl[RTC_LSB +: 2]) + CW'(1);

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    logic [FLD_W-1:0] fld;
    assign fld       = ctrl[d*FLD_STRIDE +: FLD_W];
    assign d_s[d]    = fld[0] ? CW'(FAST_SETUP) : CW'(SLOW_SETUP);
    assign d_a[d]    = fld[0] ? fast_a : CW'(SLOW_ACT);
    assign d_r[d]    = fld[0] ? fast_r : CW'(SLOW_REC);
    assign d_ien[d]  = fld[1];
    assign d_post[d] = fld[2];
  end

  always_comb begin
    s_len    = d_s[dev_sel];
    a_len    = d_a[dev_sel];
    r_len    = d_r[dev_sel];
    iordy_en = d_ien[dev_sel];
    post_sel = d_post[dev_sel];
  end

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import pio_pkg::*;
#(
  parameter int CW = 5,
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int TMO_CLKS = 1024,
  localparam int TW = $clog2(TMO_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_write,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic [CW-1:0] s_len,
  input  logic [CW-1:0] a_len,
  input  logic [CW-1:0] r_len,
  input  logic          iordy_en,
  input  logic          post_sel,
  input  logic          ata_iordy,
  input  logic [DW-1:0] ata_dd_in,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          tmo_err,
  output logic          post_en,
  output logic          ata_cs_n,
  output logic [AW-1:0] ata_da,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe
);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [TW-1:0] wcnt;
  logic [CW-1:0] a_q, r_q;
  logic          ien_q, post_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic strobe_on, cs_on, hold_req, wait_done, timeout, leave;

  assign strobe_on = (ph == PH_ACT) || (ph == PH_WAIT);
  assign cs_on     = strobe_on || (ph == PH_SETUP);
  assign hold_req  = ien_q && !ata_iordy;
  assign timeout   = (ph == PH_WAIT) && !ata_iordy && (wcnt == TW'(TMO_CLKS - 1));
  assign wait_done = (ph == PH_WAIT) && (ata_iordy || timeout);
  assign leave     = ((ph == PH_ACT) && (cnt == '0) && !hold_req) || wait_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      wcnt    <= '0;
      a_q     <= '0;
      r_q     <= '0;
      ien_q   <= 1'b0;
      post_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_SETUP;
            cnt     <= s_len - CW'(1);
            a_q     <= a_len;
            r_q     <= r_len;
            ien_q   <= iordy_en;
            post_q  <= post_sel;
            wr_q    <= start_write;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ph  <= PH_ACT;
            cnt <= a_q - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_ACT: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (hold_req) begin
            ph   <= PH_WAIT;
            wcnt <= '0;
          end else begin
            ph  <= PH_RECOV;
            cnt <= r_q - CW'(1);
          end
        end
        PH_WAIT: begin
          if (wait_done) begin
            ph  <= PH_RECOV;
            cnt <= r_q - CW'(1);
          end else begin
            wcnt <= wcnt + TW'(1);
          end
        end
        PH_RECOV: begin
          if (cnt == '0) ph <= PH_IDLE;
          else           cnt <= cnt - CW'(1);
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= leave && !wr_q;
      if (leave && !wr_q) rsp_rdata <= ata_dd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_err <= 1'b0;
    else if (timeout) tmo_err <= 1'b1;
  end

  assign busy       = (ph != PH_IDLE);
  assign post_en    = busy && post_q;
  assign ata_cs_n   = !cs_on;
  assign ata_da     = addr_q;
  assign ata_dior_n = !(strobe_on && !wr_q);
  assign ata_diow_n = !(strobe_on && wr_q);
  assign ata_dd_out = wdata_q;
  assign ata_dd_oe  = wr_q && cs_on;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  // R11
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> !ata_cs_n);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && !ata_iordy && !timeout) |=> (ph == PH_WAIT));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_pkg::*;
#(
  parameter int CLK_MHZ = 33,
  parameter int SETUP_NS = 70,
  parameter int ACT_NS = 290,
  parameter int CYC_NS = 600,
  parameter int FAST_SETUP = 1,
  parameter int TMO_CLKS = 1024,
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int DEVHEAD_ADDR = 6,
  parameter int DRV_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  output logic          tmo_err,
  output logic          chan_sec,
  output logic          post_en,
  output logic          ata_cs_n,
  output logic [AW-1:0] ata_da,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe,
  input  logic [DW-1:0] ata_dd_in,
  input  logic          ata_iordy
);

  localparam int SLOW_SETUP = ns2clk(SETUP_NS, CLK_MHZ);
  localparam int SLOW_ACT   = ns2clk(ACT_NS, CLK_MHZ);
  localparam int SLOW_CYC   = ns2clk(CYC_NS, CLK_MHZ);
  localparam int SLOW_REC   = (SLOW_CYC > SLOW_SETUP + SLOW_ACT) ?
                              (SLOW_CYC - SLOW_SETUP - SLOW_ACT) : 1;
  localparam int MAX_LEN    = (SLOW_CYC > 6) ? SLOW_CYC : 6;
  localparam int CW         = $clog2(MAX_LEN + 1);

  logic [CTRL_W-1:0] ctrl;
  logic              dev_sel, accept;
  logic [CW-1:0]     s_len, a_len, r_len;
  logic              iordy_en, post_sel;

  assign req_ready = ctrl[EN_BIT] && !busy;
  assign accept    = req_valid && req_ready;
  assign chan_sec  = ctrl[SEC_BIT];

  pio_cfg_regs #(
    .AW(AW), .DW(DW), .DEVHEAD_ADDR(DEVHEAD_ADDR), .DRV_BIT(DRV_BIT)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .acc       (accept),
    .acc_write (req_write),
    .acc_addr  (req_addr),
    .acc_wdata (req_wdata),
    .ctrl      (ctrl),
    .dev_sel   (dev_sel)
  );

  pio_timing_sel #(
    .CW(CW), .FAST_SETUP(FAST_SETUP), .SLOW_SETUP(SLOW_SETUP),
    .SLOW_ACT(SLOW_ACT), .SLOW_REC(SLOW_REC)
  ) u_sel (
    .ctrl     (ctrl),
    .dev_sel  (dev_sel),
    .s_len    (s_len),
    .a_len    (a_len),
    .r_len    (r_len),
    .iordy_en (iordy_en),
    .post_sel (post_sel)
  );

  pio_cycle_fsm #(
    .CW(CW), .AW(AW), .DW(DW), .TMO_CLKS(TMO_CLKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .start_addr  (req_addr),
    .start_wdata (req_wdata),
    .s_len       (s_len),
    .a_len       (a_len),
    .r_len       (r_len),
    .iordy_en    (iordy_en),
    .post_sel    (post_sel),
    .ata_iordy   (ata_iordy),
    .ata_dd_in   (ata_dd_in),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .tmo_err     (tmo_err),
    .post_en     (post_en),
    .ata_cs_n    (ata_cs_n),
    .ata_da      (ata_da),
    .ata_dior_n  (ata_dior_n),
    .ata_diow_n  (ata_diow_n),
    .ata_dd_out  (ata_dd_out),
    .ata_dd_oe   (ata_dd_oe)
  );

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[EN_BIT] && !busy) |=> !busy);

endmodule

// File: tb/sim_pio_strobe_gen.sv
`timescale 1ns/1ps
module sim_pio_strobe_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy, tmo_err, chan_sec, post_en;
  logic [15:0] rsp_rdata, ata_dd_out;
  logic ata_cs_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0] ata_da;
  logic [15:0] ata_dd_in = '0;
  logic ata_iordy = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // measurement results
  int su, act, rec;
  bit rsp_seen, err_seen, rdy_bad, cs_bad, post_seen, rd_strobe, wr_strobe, oe_ok;
  logic [15:0] rsp_data, dd_seen;
  logic [2:0] da_seen;

  always #5 clk = ~clk;

  pio_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .tmo_err(tmo_err), .chan_sec(chan_sec),
    .post_en(post_en), .ata_cs_n(ata_cs_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out),
    .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue one cycle and measure it at negedges until busy drops
  task automatic run_cycle(input bit wr, input logic [2:0] addr, input logic [15:0] data,
                           input int release_at, input bit inject, input logic [15:0] inj_val);
    int n;
    int guard;
    su = 0; act = 0; rec = 0; n = 0;
    rsp_seen = 0; err_seen = 0; rdy_bad = 0; cs_bad = 0; post_seen = 0;
    rd_strobe = 0; wr_strobe = 0; oe_ok = 1; rsp_data = '0; dd_seen = '0; da_seen = '0;
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_write = wr; req_addr = addr; req_wdata = data; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && n < 3000) begin
      n++;
      if (inject && n == 1) begin cfg_wdata = inj_val; cfg_we = 1'b1; end
      if (inject && n == 2) cfg_we = 1'b0;
      if (req_ready) rdy_bad = 1;
      if (post_en) post_seen = 1;
      if (!ata_dior_n || !ata_diow_n) begin
        act++;
        if (!ata_dior_n) rd_strobe = 1;
        if (!ata_diow_n) begin wr_strobe = 1; dd_seen = ata_dd_out; if (!ata_dd_oe) oe_ok = 0; end
        if (ata_cs_n) cs_bad = 1;
        da_seen = ata_da;
        if (act == release_at) ata_iordy = 1'b1;
      end else if (act == 0) begin
        su++;
      end else begin
        rec++;
        if (rec == 1) begin rsp_seen = rsp_valid; rsp_data = rsp_rdata; err_seen = tmo_err; end
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    ata_iordy = 1'b1;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!busy && !tmo_err && !rsp_valid && !post_en && !chan_sec, "R1 idle outputs", busy, 0);
    check(ata_cs_n && ata_dior_n && ata_diow_n, "R1 strobes high", ata_dior_n, 1);
    check(!req_ready, "R1 ready low", req_ready, 0);
  endtask

  task automatic test_disabled();
    bit act_seen = 0;
    bit rdy_seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy || !ata_cs_n || !ata_dior_n || !ata_diow_n) act_seen = 1;
      if (req_ready) rdy_seen = 1;
    end
    req_valid = 1'b0;
    check(!act_seen, "R2 no activity while disabled", act_seen, 0);
    check(!rdy_seen, "R2 ready low while disabled", rdy_seen, 0);
    write_cfg(16'hC000);
    @(negedge clk);
    check(req_ready, "R2 ready when enabled", req_ready, 1);
    check(chan_sec, "R13 secondary bit", chan_sec, 1);
  endtask

  task automatic test_slow_read();
    write_cfg(16'h8000 | 16'h3300);  // fast fields set but drive 0 not on fast bank
    ata_dd_in = 16'hA5C3;
    run_cycle(0, 3'd5, 16'h0, 0, 0, 16'h0);
    check(su == 3, "R4 slow setup", su, 3);
    check(act == 10, "R4 slow active", act, 10);
    check(rec == 7, "R4 slow recovery", rec, 7);
    check(!rdy_bad, "R3 ready low while busy", rdy_bad, 0);
    check(rd_strobe && !wr_strobe && !cs_bad && da_seen == 3'd5, "R11 read strobe/addr", da_seen, 5);
    check(rsp_seen && rsp_data == 16'hA5C3, "R11 read data", rsp_data, 16'hA5C3);
    check(!post_seen, "R13 post low", post_seen, 0);
  endtask

  task automatic test_fast_write();
    write_cfg(16'h8000 | 16'h2000 | 16'h0300 | 16'h0001);
    run_cycle(1, 3'd1, 16'h1234, 0, 0, 16'h0);
    check(su == 1, "R5 fast setup", su, 1);
    check(act == 4, "R5 fast active isp", act, 4);
    check(rec == 4, "R5 fast recovery", rec, 4);
    check(wr_strobe && !rd_strobe && oe_ok && dd_seen == 16'h1234, "R11 write data", dd_seen, 16'h1234);
    check(!rsp_seen, "R11 no rsp on write", rsp_seen, 0);
  endtask

  task automatic test_drive_select();
    write_cfg(16'h8000 | 16'h1000 | 16'h0010);  // drive 1 field fast, isp code 1, rtc code 0
    run_cycle(0, 3'd0, 16'h0, 0, 0, 16'h0);
    check(act == 10 && rec == 7, "R6 drive0 slow while drive1 fast", act, 10);
    run_cycle(1, 3'd6, 16'h0010, 0, 0, 16'h0);
    check(act == 10, "R7 select write uses old drive", act, 10);
    run_cycle(0, 3'd0, 16'h0, 0, 0, 16'h0);
    check(su == 1 && act == 3 && rec == 1, "R7 drive1 fast after select", act, 3);
    run_cycle(1, 3'd6, 16'h0000, 0, 0, 16'h0);
    run_cycle(0, 3'd0, 16'h0, 0, 0, 16'h0);
    check(act == 10, "R7 back to drive0", act, 10);
  endtask

  task automatic test_iordy_ext();
    write_cfg(16'h8000 | 16'h0007);  // isp code 0 -> 2 clocks, iordy and posting on
    ata_iordy = 1'b0;
    run_cycle(0, 3'd2, 16'h0, 7, 0, 16'h0);
    check(act == 7, "R8 strobe stretched", act, 7);
    check(rec == 1, "R8 recovery after stretch", rec, 1);
    check(post_seen, "R13 post high", post_seen, 1);
    check(!err_seen, "R10 no timeout on short wait", err_seen, 0);
  endtask

  task automatic test_iordy_ignored();
    write_cfg(16'h8000 | 16'h0001);
    ata_iordy = 1'b0;
    run_cycle(0, 3'd2, 16'h0, 100000, 0, 16'h0);
    check(act == 2, "R9 iordy ignored", act, 2);
  endtask

  task automatic test_mid_cfg();
    write_cfg(16'h8000);
    run_cycle(0, 3'd3, 16'h0, 0, 1, 16'h8000 | 16'h3000 | 16'h0300 | 16'h0001);
    check(su == 3 && act == 10 && rec == 7, "R12 cycle keeps old timing", act, 10);
    run_cycle(0, 3'd3, 16'h0, 0, 0, 16'h0);
    check(su == 1 && act == 5 && rec == 4, "R12 new timing next cycle", act, 5);
  endtask

  task automatic test_timeout();
    check(!tmo_err, "R10 err clear before", tmo_err, 0);
    write_cfg(16'h8000 | 16'h0003);
    ata_iordy = 1'b0;
    run_cycle(0, 3'd0, 16'h0, 100000, 0, 16'h0);
    check(act == 2 + 1024, "R10 timeout strobe length", act, 1026);
    check(err_seen && tmo_err, "R10 err set", tmo_err, 1);
    run_cycle(0, 3'd0, 16'h0, 0, 0, 16'h0);
    check(act == 2 && tmo_err, "R10 err sticky", tmo_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_disabled();
    test_slow_read();
    test_fast_write();
    test_drive_select();
    test_iordy_ext();
    test_iordy_ignored();
    test_mid_cfg();
    test_timeout();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule